// File: doc/BRIEF.md
# Event Counter Performance Monitor

This block counts hardware events for software profiling. It has one free-running cycle counter and a parameterized set of general counters. Each general counter watches one event, chosen by an event code. It counts that event only while the processor runs at a privilege level and in a security state that its filter admits. Event sources arrive as single-cycle pulses on `evt_i`. The current privilege level and security state arrive on `priv_i` and `nsec_i`.

Software reaches the unit through a word-indexed register port. A write takes effect at the clock edge where `reg_we` is high. A read is combinational from `reg_addr`. The port holds:
- a global control register;
- set/clear register pairs for counter enables and for overflow interrupt enables;
- a write-one-to-clear overflow status register;
- a select register that decides which general counter the event-type and event-count registers reach.

A counter that wraps from all ones to zero records an overflow. If that counter's interrupt enable is set, the overflow raises the level interrupt `irq_o`. Preloading a counter with a value just below the wrap point gives an interrupt after a chosen number of events.

Register indices on `reg_addr`:
- 0 control
- 1 enable-set
- 2 enable-clear
- 3 interrupt-enable-set
- 4 interrupt-enable-clear
- 5 overflow status
- 6 select
- 7 event type
- 8 event count
- 9 cycle count

Top module: `pmu_top`

## Requirements
- R1: The control register (index 0) reads back the number of general counters, NUM_CNT, in bits [15:11]. Writes to those bits have no effect. Bit 0 of the control register is the global enable, and it reads back as written.
- R2: While the global enable is 0, no counter changes value, whether cycles pass or events pulse. Software writes to the counters still take effect.
- R3: Writing a 1 in a bit of the enable-set register (index 1) turns on that counter. Writing a 1 in the same bit of the enable-clear register (index 2) turns it off. Bits written as 0 leave the enable unchanged. Bit i is general counter i and bit 31 is the cycle counter. Both indices read back the current enables, and bits of counters that are not implemented always read 0.
- R4: The interrupt-enable-set register (index 3) and the interrupt-enable-clear register (index 4) work on the interrupt enables exactly as R3 describes for the counter enables.
- R5: The select register (index 6, 5 bits) chooses the general counter reached through the event-type register (index 7) and the event-count register (index 8). If the selected index is NUM_CNT or higher, those two registers read 0 and writes to them change no counter.
- R6: The low 8 bits of an event-type register hold the event code. Each code counts pulses on one bit of `evt_i`:
  - 0x06 counts `evt_i` bit 0 (load)
  - 0x07 counts bit 1 (store)
  - 0x08 counts bit 2 (instruction)
  - 0x0C counts bit 3 (branch)
  - 0x0E counts bit 4 (return)
  - 0x10 counts bit 5 (mispredict)
  - 0x14 counts bit 6 (instruction cache access)

  Any other code never counts.
- R7: Bits [31:27] of an event-type register filter counting by context. `priv_i` gives the privilege level: 0 = PL0, 1 = PL1, 2 = hypervisor, 3 = never counted. `nsec_i` is 1 in the non-secure state. The bits act as follows:
  - bit 31 set excludes PL1;
  - bit 30 set excludes PL0;
  - bit 29 chooses which state PL1 counts in: 0 counts only non-secure, 1 counts only secure;
  - bit 28 makes the same choice for PL0;
  - bit 27 set counts the hypervisor level in either state.

  For the branch event this gives:
  - 0x4000000C counts only non-secure PL1;
  - 0x8000000C counts only non-secure PL0;
  - 0x6000000C counts only secure PL1;
  - 0x9000000C counts only secure PL0;
  - 0x3800000C counts secure PL0, secure PL1 and the hypervisor.
- R8: Counters are 32 bits wide and writable through the event-count register. A counter preloaded with 0xFFFFFFFD reaches 0xFFFFFFFF after two matching events. The third event wraps it to 0 and sets bit i of the overflow status register.
- R9: The cycle counter (index 9) adds one on every clock edge while both the global enable and enable bit 31 are set. When it wraps from 0xFFFFFFFF to 0, it sets overflow status bit 31.
- R10: `irq_o` is high exactly when some overflow status bit and its interrupt enable are both 1. It stays high until that status bit or that enable is cleared.
- R11: Writing a 1 to a bit of the overflow status register (index 5) clears that bit. Zeros have no effect, so reading the register and writing the value back clears every pending overflow. If an overflow occurs in the same cycle as the clear, the new overflow wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| evt_i | input | 7 | Per-cycle event pulses, one bit per supported event |
| priv_i | input | 2 | Current privilege level |
| nsec_i | input | 1 | 1 when running in the non-secure state |
| irq_o | output | 1 | Level overflow interrupt |

## Verification
The bound checker watches the cycle counter on every cycle. It checks that the counter stays frozen while the global enable is off, and that its wrap sets status bit 31. It also checks on every cycle that set and clear writes land in the enable mask, that a write-one clear removes a status bit, that the counter-count field in the control register is constant, and that the interrupt holds until status or enable is cleared. Only the directed scenarios can show the rest:
- the mapping from event code to event input;
- the five privilege and security filter encodings over all six contexts;
- the preload-and-overflow count;
- the handling of an unimplemented select index;
- the read-then-write-back clearing of status.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

   localparam int REG_W    = 32;
   localparam int NUM_EVT  = 7;
   localparam int NFLD_LSB = 11;
   localparam int CYC_BIT  = 31;

   typedef enum logic [3:0] {
      A_CTRL    = 4'd0,
      A_CEN_SET = 4'd1,
      A_CEN_CLR = 4'd2,
      A_IEN_SET = 4'd3,
      A_IEN_CLR = 4'd4,
      A_OVF     = 4'd5,
      A_SEL     = 4'd6,
      A_TYPE    = 4'd7,
      A_COUNT   = 4'd8,
      A_CYCLE   = 4'd9
   } reg_idx_e;

   // privilege level encoding on priv_i
   typedef enum logic [1:0] {
      LVL_USR = 2'd0,
      LVL_KRN = 2'd1,
      LVL_HYP = 2'd2
   } lvl_e;

   // context filter held in event-type bits [31:27]
   typedef struct packed {
      logic excl_krn;   // drop PL1
      logic excl_usr;   // drop PL0
      logic sec_krn;    // PL1 counts in secure (1) or non-secure (0) state
      logic sec_usr;    // PL0 counts in secure (1) or non-secure (0) state
      logic incl_hyp;   // count hypervisor level
   } ctx_filt_t;

   // event code watched by evt_i bit k
   function automatic logic [7:0] code_of(input int k);
      case (k)
         0:       code_of = 8'h06;
         1:       code_of = 8'h07;
         2:       code_of = 8'h08;
         3:       code_of = 8'h0C;
         4:       code_of = 8'h0E;
         5:       code_of = 8'h10;
         6:       code_of = 8'h14;
         default: code_of = 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/pmu_evt_filter.sv
module pmu_evt_filter
   import pmu_pkg::*;
(
   input  ctx_filt_t            filt,
   input  logic [7:0]           code,
   input  logic [NUM_EVT-1:0]   evt,
   input  logic [1:0]           priv,
   input  logic                 nsec,
   output logic                 hit
);

   logic [NUM_EVT-1:0] match;
   logic               ctx_ok;

   for (genvar k = 0; k < NUM_EVT; k++) begin : g_code
      assign match[k] = evt[k] && (code == code_of(k));
   end

   always_comb begin
      case (priv)
         LVL_USR: ctx_ok = !filt.excl_usr && (filt.sec_usr ? !nsec : nsec);
         LVL_KRN: ctx_ok = !filt.excl_krn && (filt.sec_krn ? !nsec : nsec);
         LVL_HYP: ctx_ok = filt.incl_hyp;
         default: ctx_ok = 1'b0;
      endcase
   end

   assign hit = ctx_ok && (|match);

endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   output logic [W-1:0] cnt,
   output logic         wrap
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (ld)  cnt <= ld_val;
      else if (inc) cnt <= cnt + W'(1);
   end

   // a software load in the same cycle suppresses the wrap
   assign wrap = inc && !ld && (&cnt);

endmodule

// File: rtl/pmu_top.sv
module pmu_top
   import pmu_pkg::*;
#(
   parameter int NUM_CNT = 4,
   parameter int CNT_W   = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_we,
   input  logic [3:0]           reg_addr,
   input  logic [REG_W-1:0]     reg_wdata,
   output logic [REG_W-1:0]     reg_rdata,
   input  logic [NUM_EVT-1:0]   evt_i,
   input  logic [1:0]           priv_i,
   input  logic                 nsec_i,
   output logic                 irq_o
);

   localparam logic [REG_W-1:0] IMPL_MASK =
      (REG_W'(1) << CYC_BIT) | ((REG_W'(1) << NUM_CNT) - REG_W'(1));

   if (NUM_CNT < 1 || NUM_CNT > 31) begin : g_bad_num
      $error("pmu_top: NUM_CNT must lie in 1..31");
   end
   if (CNT_W < 8 || CNT_W > REG_W) begin : g_bad_w
      $error("pmu_top: CNT_W must lie in 8..32");
   end

   logic                        glob_en_q;
   logic [REG_W-1:0]            cnten_q, inten_q, ovf_q;
   logic [4:0]                  sel_q;
   logic [NUM_CNT-1:0]          wrap_g;
   logic [NUM_CNT-1:0][REG_W-1:0] cnt_rd, type_rd;
   logic [CNT_W-1:0]            cyc_val;
   logic                        cyc_wrap;
   logic [REG_W-1:0]            wrap_v, w1c_v, sel_cnt, sel_type;
   logic                        sel_ok;

   // ---------------- general counters ----------------
   for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
      ctx_filt_t        filt_q;
      logic [7:0]       code_q;
      logic             hit, wr_type, wr_cnt;
      logic [CNT_W-1:0] val;

      assign wr_type = reg_we && (reg_addr == A_TYPE)  && (sel_q == 5'(i));
      assign wr_cnt  = reg_we && (reg_addr == A_COUNT) && (sel_q == 5'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            filt_q <= '0;
            code_q <= '0;
         end else if (wr_type) begin
            filt_q <= reg_wdata[31:27];
            code_q <= reg_wdata[7:0];
         end
      end

      pmu_evt_filter u_filt (
         .filt (filt_q),
         .code (code_q),
         .evt  (evt_i),
         .priv (priv_i),
         .nsec (nsec_i),
         .hit  (hit)
      );

      pmu_counter #(.W(CNT_W)) u_cnt (
         .clk    (clk),
         .rst_n  (rst_n),
         .inc    (glob_en_q && cnten_q[i] && hit),
         .ld     (wr_cnt),
         .ld_val (reg_wdata[CNT_W-1:0]),
         .cnt    (val),
         .wrap   (wrap_g[i])
      );

      assign cnt_rd[i]  = REG_W'(val);
      assign type_rd[i] = {filt_q, 19'd0, code_q};
   end

   // ---------------- cycle counter ----------------
   pmu_counter #(.W(CNT_W)) u_cyc (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc    (glob_en_q && cnten_q[CYC_BIT]),
      .ld     (reg_we && (reg_addr == A_CYCLE)),
      .ld_val (reg_wdata[CNT_W-1:0]),
      .cnt    (cyc_val),
      .wrap   (cyc_wrap)
   );

   assign wrap_v = {cyc_wrap, 31'(wrap_g)};
   assign w1c_v  = (reg_we && (reg_addr == A_OVF)) ? reg_wdata : '0;

   // ---------------- control state ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         glob_en_q <= 1'b0;
         cnten_q   <= '0;
         inten_q   <= '0;
         ovf_q     <= '0;
         sel_q     <= '0;
      end else begin
         if (reg_we) begin
            case (reg_addr)
               A_CTRL:    glob_en_q <= reg_wdata[0];
               A_CEN_SET: cnten_q   <= (cnten_q | reg_wdata) & IMPL_MASK;
               A_CEN_CLR: cnten_q   <= cnten_q & ~reg_wdata;
               A_IEN_SET: inten_q   <= (inten_q | reg_wdata) & IMPL_MASK;
               A_IEN_CLR: inten_q   <= inten_q & ~reg_wdata;
               A_SEL:     sel_q     <= reg_wdata[4:0];
               default:   ;
            endcase
         end
         // fresh overflow takes priority over a same-cycle clear
         ovf_q <= ((ovf_q & ~w1c_v) | wrap_v) & IMPL_MASK;
      end
   end

   assign irq_o = |(ovf_q & inten_q);

   // ---------------- read path ----------------
   assign sel_ok = (sel_q < 5'(NUM_CNT));

   always_comb begin
      sel_cnt  = '0;
      sel_type = '0;
      for (int i = 0; i < NUM_CNT; i++) begin
         if (sel_q == 5'(i)) begin
            sel_cnt  = cnt_rd[i];
            sel_type = type_rd[i];
         end
      end
   end

   always_comb begin
      case (reg_addr)
         A_CTRL:    reg_rdata = (REG_W'(NUM_CNT) << NFLD_LSB) | REG_W'(glob_en_q);
         A_CEN_SET,
         A_CEN_CLR: reg_rdata = cnten_q;
         A_IEN_SET,
         A_IEN_CLR: reg_rdata = inten_q;
         A_OVF:     reg_rdata = ovf_q;
         A_SEL:     reg_rdata = REG_W'(sel_q);
         A_TYPE:    reg_rdata = sel_ok ? sel_type : '0;
         A_COUNT:   reg_rdata = sel_ok ? sel_cnt  : '0;
         A_CYCLE:   reg_rdata = REG_W'(cyc_val);
         default:   reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/pmu_chk.sv
module pmu_chk
   import pmu_pkg::*;
#(
   parameter int NUM_CNT = 4,
   parameter int CNT_W   = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_we,
   input logic [3:0]       reg_addr,
   input logic [31:0]      reg_wdata,
   input logic [31:0]      reg_rdata,
   input logic             irq_o,
   input logic [CNT_W-1:0] cyc_cnt,
   input logic [31:0]      ovf,
   input logic [31:0]      cnten,
   input logic             ctrl_en
);

   localparam logic [31:0] MASK =
      32'h8000_0000 | ((32'h1 << NUM_CNT) - 32'h1);

   logic cyc_ld, cyc_about_to_wrap;
   assign cyc_ld            = reg_we && (reg_addr == A_CYCLE);
   assign cyc_about_to_wrap = ctrl_en && cnten[31] && (&cyc_cnt) && !cyc_ld;

   // R1: counter-count field is fixed
   p_nfield_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == A_CTRL) |-> (reg_rdata[15:11] == 5'(NUM_CNT)));

   // R2: nothing counts while globally disabled
   p_frozen_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_en && !cyc_ld) |=> $stable(cyc_cnt));

   // R3: set writes land, clear writes remove
   p_enset_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == A_CEN_SET) |=>
         ((cnten & $past(reg_wdata & MASK)) == $past(reg_wdata & MASK)));

   p_enclr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == A_CEN_CLR) |=> ((cnten & $past(reg_wdata)) == 32'd0));

   // R9: cycle counter wrap records overflow bit 31
   p_cycwrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_about_to_wrap |=> (ovf[31] && (cyc_cnt == '0)));

   // R10: interrupt holds until status or enable is cleared
   p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !(reg_we && (reg_addr == A_OVF || reg_addr == A_IEN_CLR))) |=> irq_o);

   // R11: write-one clear of bit 31 when no new wrap competes
   p_w1c_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == A_OVF && reg_wdata[31] && !cyc_about_to_wrap) |=> !ovf[31]);

endmodule

bind pmu_top pmu_chk #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .irq_o     (irq_o),
   .cyc_cnt   (cyc_val),
   .ovf       (ovf_q),
   .cnten     (cnten_q),
   .ctrl_en   (glob_en_q)
);

// File: tb/tb_pmu_top.sv
module tb_pmu_top;

   localparam int NC = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = 4'd0;
   logic [31:0] reg_wdata = 32'd0;
   logic [31:0] reg_rdata;
   logic [6:0]  evt_i = 7'd0;
   logic [1:0]  priv_i = 2'd1;
   logic        nsec_i = 1'b1;
   logic        irq_o;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   pmu_top #(.NUM_CNT(NC), .CNT_W(32)) dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_i(evt_i),
      .priv_i(priv_i), .nsec_i(nsec_i), .irq_o(irq_o)
   );

   localparam logic [3:0] I_CTRL = 4'd0, I_CSET = 4'd1, I_CCLR = 4'd2,
                          I_ISET = 4'd3, I_ICLR = 4'd4, I_OVF = 4'd5,
                          I_SEL = 4'd6, I_TYPE = 4'd7, I_CNT = 4'd8,
                          I_CYC = 4'd9;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %08h expected %08h", req, act, exp);
      end
   endtask

   // called at a negedge, returns at the next negedge
   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic pulse(input logic [6:0] b, input int n);
      for (int k = 0; k < n; k++) begin
         evt_i = b;
         @(posedge clk);
         @(negedge clk);
         evt_i = 7'd0;
      end
   endtask

   function automatic logic [7:0] code(input int k);
      case (k)
         0: code = 8'h06; 1: code = 8'h07; 2: code = 8'h08; 3: code = 8'h0C;
         4: code = 8'h0E; 5: code = 8'h10; default: code = 8'h14;
      endcase
   endfunction

   task automatic t_reset();
      logic [31:0] v;
      rd(I_CTRL, v); check("R1 ctrl reset", v, 32'(NC) << 11);
      rd(I_CSET, v); check("R3 enables reset", v, 0);
      rd(I_OVF, v);  check("R11 status reset", v, 0);
      rd(I_CNT, v);  check("R8 count reset", v, 0);
      check("R10 irq reset", 32'(irq_o), 0);
      wr(I_CTRL, 32'hFFFF_FFFF);
      rd(I_CTRL, v); check("R1 field read-only", v, (32'(NC) << 11) | 1);
   endtask

   task automatic t_enables();
      logic [31:0] v;
      wr(I_CSET, 32'hFFFF_FFFF); rd(I_CCLR, v); check("R3 set all", v, 32'h8000_000F);
      wr(I_CCLR, 32'h0);         rd(I_CSET, v); check("R3 zero clr", v, 32'h8000_000F);
      wr(I_CCLR, 32'h8000_0005); rd(I_CSET, v); check("R3 clr some", v, 32'h0000_000A);
      wr(I_CSET, 32'h0);         rd(I_CSET, v); check("R3 zero set", v, 32'h0000_000A);
      wr(I_CCLR, 32'hFFFF_FFFF); rd(I_CSET, v); check("R3 clr all", v, 0);
      wr(I_ISET, 32'h8000_0003); rd(I_ICLR, v); check("R4 set", v, 32'h8000_0003);
      wr(I_ICLR, 32'h0);         rd(I_ISET, v); check("R4 zero clr", v, 32'h8000_0003);
      wr(I_ICLR, 32'hFFFF_FFFF); rd(I_ISET, v); check("R4 clr all", v, 0);
   endtask

   task automatic t_codes();
      logic [31:0] v;
      priv_i = 2'd1; nsec_i = 1'b1;
      wr(I_CSET, 32'h1);
      wr(I_SEL, 0);
      for (int k = 0; k < 7; k++) begin
         wr(I_TYPE, 32'(code(k)));
         wr(I_CNT, 0);
         pulse(~(7'd1 << k), 1);
         rd(I_CNT, v); check("R6 other events ignored", v, 0);
         pulse(7'd1 << k, 1);
         rd(I_CNT, v); check("R6 own event counts", v, 1);
      end
      wr(I_TYPE, 32'h0A); wr(I_CNT, 0);
      pulse(7'h7F, 2);
      rd(I_CNT, v); check("R6 unsupported code", v, 0);
      wr(I_CCLR, 32'h1);
   endtask

   task automatic t_filter();
      logic [31:0] v, exp;
      logic [31:0] enc [5] = '{32'h4000_000C, 32'h8000_000C, 32'h6000_000C,
                               32'h9000_000C, 32'h3800_000C};
      logic [5:0]  msk [5] = '{6'b000010, 6'b000001, 6'b010000,
                               6'b001000, 6'b111100};
      wr(I_SEL, 2);
      wr(I_CSET, 32'h4);
      for (int e = 0; e < 5; e++) begin
         wr(I_TYPE, enc[e]);
         wr(I_CNT, 0);
         exp = 0;
         for (int c = 0; c < 6; c++) begin
            priv_i = 2'(c % 3);
            nsec_i = (c < 3);
            pulse(7'b000_1000, 1);
            exp = exp + 32'(msk[e][c]);
            rd(I_CNT, v); check("R7 context filter", v, exp);
         end
      end
      priv_i = 2'd1; nsec_i = 1'b1;
      wr(I_CCLR, 32'h4);
   endtask

   task automatic t_overflow();
      logic [31:0] v;
      wr(I_SEL, 0); wr(I_TYPE, 32'h08); wr(I_CNT, 32'hFFFF_FFFD);
      wr(I_ISET, 32'h1); wr(I_CSET, 32'h1);
      pulse(7'b000_0100, 2);
      rd(I_CNT, v); check("R8 two events", v, 32'hFFFF_FFFF);
      rd(I_OVF, v); check("R8 no overflow yet", v, 0);
      check("R10 irq low", 32'(irq_o), 0);
      pulse(7'b000_0100, 1);
      rd(I_CNT, v); check("R8 wrap to zero", v, 0);
      rd(I_OVF, v); check("R8 status bit", v, 1);
      check("R10 irq high", 32'(irq_o), 1);
      wr(I_ICLR, 32'h1); check("R10 irq off when disabled", 32'(irq_o), 0);
      wr(I_ISET, 32'h1); check("R10 irq back", 32'(irq_o), 1);
      wr(I_SEL, 1); wr(I_TYPE, 32'h08); wr(I_CNT, 32'hFFFF_FFFF);
      wr(I_CSET, 32'h2);
      pulse(7'b000_0100, 1);
      rd(I_OVF, v); check("R8 both overflow", v, 3);
      wr(I_OVF, 0); rd(I_OVF, v); check("R11 zero write", v, 3);
      wr(I_OVF, 1); rd(I_OVF, v); check("R11 clear bit0", v, 2);
      check("R10 unenabled overflow", 32'(irq_o), 0);
      wr(I_ISET, 32'h2); check("R10 enable bit1", 32'(irq_o), 1);
      rd(I_OVF, v); wr(I_OVF, v);
      rd(I_OVF, v); check("R11 writeback clears", v, 0);
      check("R11 irq dropped", 32'(irq_o), 0);
      wr(I_CCLR, 32'h3); wr(I_ICLR, 32'hFFFF_FFFF);
   endtask

   task automatic t_unimpl();
      logic [31:0] v;
      wr(I_SEL, 0); wr(I_CNT, 32'h55);
      wr(I_SEL, NC);
      rd(I_SEL, v);  check("R5 select readback", v, NC);
      wr(I_CNT, 5);  wr(I_TYPE, 32'h14);
      rd(I_CNT, v);  check("R5 unimpl count zero", v, 0);
      rd(I_TYPE, v); check("R5 unimpl type zero", v, 0);
      wr(I_SEL, 0);
      rd(I_CNT, v);  check("R5 counter0 untouched", v, 32'h55);
      rd(I_TYPE, v); check("R5 type0 untouched", v, 32'h08);
   endtask

   task automatic t_cycle();
      logic [31:0] v;
      wr(I_CTRL, 0);
      wr(I_CSET, 32'h8000_0000);
      wr(I_CYC, 100);
      wr(I_CTRL, 1);
      repeat (3) @(negedge clk);
      wr(I_CTRL, 0);
      rd(I_CYC, v); check("R9 cycle count", v, 104);
      wr(I_CYC, 32'hFFFF_FFFE);
      wr(I_CTRL, 1);
      @(negedge clk);
      wr(I_CTRL, 0);
      rd(I_CYC, v); check("R9 cycle wrap", v, 0);
      rd(I_OVF, v); check("R9 status bit31", v, 32'h8000_0000);
      repeat (5) @(negedge clk);
      rd(I_CYC, v); check("R2 cycle frozen", v, 0);
      wr(I_OVF, 32'h8000_0000);
   endtask

   task automatic t_global_off();
      logic [31:0] v;
      wr(I_SEL, 0); wr(I_CNT, 7); wr(I_CSET, 32'h1);
      pulse(7'b000_0100, 3);
      rd(I_CNT, v); check("R2 events ignored when off", v, 7);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_enables();
      t_codes();
      t_filter();
      t_overflow();
      t_unimpl();
      t_cycle();
      t_global_off();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule